// File: doc/BRIEF.md
# Half-Bridge Gate Fault Qualifier

This block sits between the commutation logic and one half-bridge of a three-phase gate pre-driver. It receives the high-side and low-side gate requests. It also receives two analog comparator results. One flags desaturation of the high-side switch. The other reports whether the switch node is above half of the supply. From these it produces the gate enables that are actually applied. Every change of the requested side first passes through a deadtime with both gates off. After that, a blanking interval keeps the comparators from being judged while the node is still slewing.

A phase error is judged once, at the end of deadtime plus blanking. The high side must have pulled the node high. The low side must have pulled it low. Desaturation is watched only while the high side is conducting past blanking. It must persist through a digital filter before it counts as a fault, and a shorter episode resets the filter. Qualified faults appear as single-cycle pulses.

Unless shutdown is disabled, a qualified fault latches a trip. The trip turns both gates off and stays set until a fault-reset pulse. The trip output is meant to be ORed across the three phases and fed back into each phase's trip input, so one fault stops the whole bridge.

Top module: `halfbridge_fault_qual`

## Requirements
- R1: A gate is enabled only while exactly one of `hsCmd`/`lsCmd` is high. Both high or both low give no enable, and the two enables are never high together.
- R2: Take the first rising clock edge that samples a new single-side request as edge 1. That side's enable rises after edge DEAD_CYC+1. Both gates stay off from edge 1 onward until then.
- R3: A request change during deadtime or blanking restarts the sequence for the new request. The abandoned side's phase check is never made.
- R4: `desatRaw` and `phaseRaw` pass through SYNC_STAGES flops before use. The phase check samples the synchronized node level in the last blanking cycle, so its pulse appears after edge DEAD_CYC+BLANK_CYC+1.
- R5: `hsPhaseFault` pulses for one cycle when the high side is requested and the node reads low (`phaseRaw`=0) at the check. `lsPhaseFault` pulses when the low side is requested and the node reads high (`phaseRaw`=1).
- R6: Desaturation is evaluated only while the high side is enabled past blanking. It is never evaluated during deadtime, during blanking, or while the low side is on.
- R7: `desatFault` pulses once when the synchronized desaturation input stays high for FILT_CYC consecutive evaluated cycles. With the high side running, a raw pulse of w cycles first shows at edge SYNC_STAGES+FILT_CYC if w ≥ FILT_CYC. A shorter pulse is ignored and restarts the filter from zero.
- R8: With `sdDisable` low, any fault pulse sets `tripOut`. Both enables are low in the same cycle as the pulse.
- R9: With `sdDisable` high, the fault pulses still appear, but `tripOut` stays low and the enables keep following the requests.
- R10: `tripOut` holds until `faultClear` is sampled high. A request still present after the clear edge goes through a full deadtime again, and its enable rises DEAD_CYC+2 edges after the clear edge.
- R11: While `tripIn` is high, both enables are low. `tripOut` is unaffected. After `tripIn` falls, the active request restarts at deadtime and is enabled after DEAD_CYC+1 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hsCmd | input | 1 | High-side gate request |
| lsCmd | input | 1 | Low-side gate request |
| desatRaw | input | 1 | Desaturation comparator output, asynchronous |
| phaseRaw | input | 1 | Switch node above half supply, asynchronous |
| sdDisable | input | 1 | Report faults without tripping the outputs |
| faultClear | input | 1 | Releases a latched trip |
| tripIn | input | 1 | Trip from the other phases, forces gates off |
| hsEnable | output | 1 | Applied high-side gate enable |
| lsEnable | output | 1 | Applied low-side gate enable |
| desatFault | output | 1 | One-cycle qualified desaturation pulse |
| hsPhaseFault | output | 1 | One-cycle high-side phase error pulse |
| lsPhaseFault | output | 1 | One-cycle low-side phase error pulse |
| tripOut | output | 1 | Latched local trip, for the bridge-wide OR |

## Verification
The bench builds the block with DEAD_CYC=3, BLANK_CYC=2, FILT_CYC=4 and two synchronizer stages. With these values one whole turn-on sequence fits in about a dozen cycles. That makes it practical to sweep every combination of requested side, node level and shutdown mode. It also covers every desaturation pulse width from one cycle to two past the filter length. The short blanking lets a request change land in the very last blanking cycle, which is the boundary where a stale phase check would otherwise slip through. The exact edge at which each enable and fault pulse appears is predicted from the parameter sums.

// File: rtl/hbfq_pkg.sv
package hbfq_pkg;

  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_HI   = 2'd1,
    SIDE_LO   = 2'd2
  } side_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DEAD  = 2'd1,
    ST_BLANK = 2'd2,
    ST_RUN   = 2'd3
  } seqState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic gateHi;   // high side may conduct
    logic gateLo;   // low side may conduct
    logic chkHi;    // last blanking cycle of a high-side turn-on
    logic chkLo;    // last blanking cycle of a low-side turn-on
    logic filtEn;   // desaturation filter may count
  } strobe_t;

endpackage

// File: rtl/hbfq_ctrl.sv
module hbfq_ctrl
  import hbfq_pkg::*;
#(
  parameter int DEAD_CYC  = 20,
  parameter int BLANK_CYC = 25
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    hsCmd,
  input  logic    lsCmd,
  input  logic    tripActive,
  output strobe_t strb
);

  localparam int MAX_CYC = (DEAD_CYC > BLANK_CYC) ? DEAD_CYC : BLANK_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] DEAD_LAST  = CW'(DEAD_CYC - 1);
  localparam logic [CW-1:0] BLANK_LAST = CW'(BLANK_CYC - 1);

  side_e     reqSide;
  side_e     side;
  seqState_e st;
  logic [CW-1:0] cnt;
  logic      reqHeld;
  logic      lastBlank;

  // a request exists only when exactly one side asks
  always_comb begin
    case ({hsCmd, lsCmd})
      2'b10:   reqSide = SIDE_HI;
      2'b01:   reqSide = SIDE_LO;
      default: reqSide = SIDE_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st   <= ST_IDLE;
      side <= SIDE_NONE;
      cnt  <= '0;
    end else if (tripActive) begin
      st   <= ST_IDLE;
      side <= SIDE_NONE;
      cnt  <= '0;
    end else if (reqSide != side) begin
      side <= reqSide;
      cnt  <= '0;
      st   <= (reqSide == SIDE_NONE) ? ST_IDLE : ST_DEAD;
    end else begin
      case (st)
        ST_DEAD: begin
          if (cnt == DEAD_LAST) begin
            st  <= ST_BLANK;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_BLANK: begin
          if (cnt == BLANK_LAST) begin
            st  <= ST_RUN;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: cnt <= '0;
      endcase
    end
  end

  // the check fires only if the sequence is not being abandoned this cycle
  assign reqHeld   = (reqSide == side) && !tripActive;
  assign lastBlank = (st == ST_BLANK) && (cnt == BLANK_LAST) && reqHeld;

  always_comb begin
    strb.gateHi = (side == SIDE_HI) && ((st == ST_BLANK) || (st == ST_RUN));
    strb.gateLo = (side == SIDE_LO) && ((st == ST_BLANK) || (st == ST_RUN));
    strb.chkHi  = lastBlank && (side == SIDE_HI);
    strb.chkLo  = lastBlank && (side == SIDE_LO);
    strb.filtEn = (side == SIDE_HI) && (st == ST_RUN);
  end

endmodule

// File: rtl/hbfq_datapath.sv
module hbfq_datapath
  import hbfq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 50
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    desatRaw,
  input  logic    phaseRaw,
  input  logic    sdDisable,
  input  logic    faultClear,
  input  logic    tripIn,
  input  strobe_t strb,
  output logic    hsEnable,
  output logic    lsEnable,
  output logic    desatFault,
  output logic    hsPhaseFault,
  output logic    lsPhaseFault,
  output logic    tripOut,
  output logic    tripActive
);

  localparam int NCMP = 2;                    // bit 0 desaturation, bit 1 node level
  localparam int FW   = $clog2(FILT_CYC + 1);
  localparam logic [FW-1:0] FILT_LAST = FW'(FILT_CYC - 1);
  localparam logic [FW-1:0] FILT_SAT  = FW'(FILT_CYC);

  logic [NCMP-1:0] rawVec;
  logic [NCMP-1:0] syncVec;
  logic            desatS;
  logic            phaseS;

  assign rawVec = {phaseRaw, desatRaw};

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    logic [NCMP-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else       q <= rawVec;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else       q <= g_sync[s-1].q;
      end
    end
  end

  assign syncVec = g_sync[SYNC_STAGES-1].q;
  assign desatS  = syncVec[0];
  assign phaseS  = syncVec[1];

  // desaturation filter: consecutive count, zeroed on any gap, saturates after a hit
  logic [FW-1:0] filtCnt;
  logic          desatHit;
  logic          hsPhHit;
  logic          lsPhHit;
  logic          anyHit;
  logic          tripLat;

  assign desatHit = strb.filtEn && desatS && (filtCnt == FILT_LAST);
  assign hsPhHit  = strb.chkHi && !phaseS;
  assign lsPhHit  = strb.chkLo && phaseS;
  assign anyHit   = desatHit || hsPhHit || lsPhHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtCnt <= '0;
    end else if (!strb.filtEn || !desatS) begin
      filtCnt <= '0;
    end else if (filtCnt != FILT_SAT) begin
      filtCnt <= filtCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      desatFault   <= 1'b0;
      hsPhaseFault <= 1'b0;
      lsPhaseFault <= 1'b0;
    end else begin
      desatFault   <= desatHit;
      hsPhaseFault <= hsPhHit;
      lsPhaseFault <= lsPhHit;
    end
  end

  // a new fault wins over a simultaneous clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tripLat <= 1'b0;
    end else if (anyHit && !sdDisable) begin
      tripLat <= 1'b1;
    end else if (faultClear) begin
      tripLat <= 1'b0;
    end
  end

  assign tripOut    = tripLat;
  assign tripActive = tripLat || tripIn;
  assign hsEnable   = strb.gateHi && !tripActive;
  assign lsEnable   = strb.gateLo && !tripActive;

endmodule

// File: rtl/halfbridge_fault_qual.sv
module halfbridge_fault_qual
  import hbfq_pkg::*;
#(
  parameter int DEAD_CYC    = 20,
  parameter int BLANK_CYC   = 25,
  parameter int FILT_CYC    = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic hsCmd,
  input  logic lsCmd,
  input  logic desatRaw,
  input  logic phaseRaw,
  input  logic sdDisable,
  input  logic faultClear,
  input  logic tripIn,
  output logic hsEnable,
  output logic lsEnable,
  output logic desatFault,
  output logic hsPhaseFault,
  output logic lsPhaseFault,
  output logic tripOut
);

  strobe_t strb;
  logic    tripActive;

  hbfq_ctrl #(
    .DEAD_CYC (DEAD_CYC),
    .BLANK_CYC(BLANK_CYC)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .hsCmd     (hsCmd),
    .lsCmd     (lsCmd),
    .tripActive(tripActive),
    .strb      (strb)
  );

  hbfq_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_CYC   (FILT_CYC)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .desatRaw    (desatRaw),
    .phaseRaw    (phaseRaw),
    .sdDisable   (sdDisable),
    .faultClear  (faultClear),
    .tripIn      (tripIn),
    .strb        (strb),
    .hsEnable    (hsEnable),
    .lsEnable    (lsEnable),
    .desatFault  (desatFault),
    .hsPhaseFault(hsPhaseFault),
    .lsPhaseFault(lsPhaseFault),
    .tripOut     (tripOut),
    .tripActive  (tripActive)
  );

endmodule

// File: rtl/hbfq_checker.sv
module hbfq_checker #(
  parameter int FILT_CYC = 50
) (
  input logic clk,
  input logic rstN,
  input logic hsCmd,
  input logic lsCmd,
  input logic sdDisable,
  input logic faultClear,
  input logic tripIn,
  input logic hsEnable,
  input logic lsEnable,
  input logic desatFault,
  input logic hsPhaseFault,
  input logic lsPhaseFault,
  input logic tripOut
);

  AST_GATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(hsEnable && lsEnable)); // R1

  AST_HI_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    hsEnable |-> $past(hsCmd && !lsCmd)); // R1

  AST_LO_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    lsEnable |-> $past(lsCmd && !hsCmd)); // R1

  AST_DEAD_GAP_LH: assert property (@(posedge clk) disable iff (!rstN)
    lsEnable |=> !hsEnable); // R2

  AST_DEAD_GAP_HL: assert property (@(posedge clk) disable iff (!rstN)
    hsEnable |=> !lsEnable); // R2

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hsPhaseFault, lsPhaseFault})); // R5

  if (FILT_CYC > 1) begin : g_single
    AST_DESAT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
      desatFault |=> !desatFault); // R7
  end

  AST_TRIP_GATES_OFF: assert property (@(posedge clk) disable iff (!rstN)
    tripOut |-> (!hsEnable && !lsEnable)); // R8

  AST_FAULT_TRIPS: assert property (@(posedge clk) disable iff (!rstN)
    ((desatFault || hsPhaseFault || lsPhaseFault) && !$past(sdDisable)) |-> tripOut); // R8

  AST_SD_NO_TRIP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tripOut) |-> !$past(sdDisable)); // R9

  AST_TRIP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (tripOut && !faultClear) |=> tripOut); // R10

  AST_TRIPIN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    tripIn |-> (!hsEnable && !lsEnable)); // R11

endmodule

bind halfbridge_fault_qual hbfq_checker #(
  .FILT_CYC(FILT_CYC)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .hsCmd       (hsCmd),
  .lsCmd       (lsCmd),
  .sdDisable   (sdDisable),
  .faultClear  (faultClear),
  .tripIn      (tripIn),
  .hsEnable    (hsEnable),
  .lsEnable    (lsEnable),
  .desatFault  (desatFault),
  .hsPhaseFault(hsPhaseFault),
  .lsPhaseFault(lsPhaseFault),
  .tripOut     (tripOut)
);

// File: tb/halfbridge_fault_qual_tb_top.sv
`timescale 1ns/1ps
module halfbridge_fault_qual_tb_top;

  localparam int D = 3;
  localparam int B = 2;
  localparam int F = 4;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hsCmd = 0, lsCmd = 0, desatRaw = 0, phaseRaw = 0;
  logic sdDisable = 0, faultClear = 0, tripIn = 0;
  logic hsEnable, lsEnable, desatFault, hsPhaseFault, lsPhaseFault, tripOut;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  int idx;
  int firstHsEn, firstLsEn, firstDesat, firstHsPh, firstLsPh;
  int cntDesat, cntHsPh, cntLsPh;

  always #2.5 clk = ~clk;

  halfbridge_fault_qual #(
    .DEAD_CYC(D), .BLANK_CYC(B), .FILT_CYC(F), .SYNC_STAGES(S)
  ) dut_i (
    .clk(clk), .rstN(rstN), .hsCmd(hsCmd), .lsCmd(lsCmd),
    .desatRaw(desatRaw), .phaseRaw(phaseRaw), .sdDisable(sdDisable),
    .faultClear(faultClear), .tripIn(tripIn),
    .hsEnable(hsEnable), .lsEnable(lsEnable), .desatFault(desatFault),
    .hsPhaseFault(hsPhaseFault), .lsPhaseFault(lsPhaseFault), .tripOut(tripOut)
  );

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearObs();
    idx = 0;
    firstHsEn = 0; firstLsEn = 0; firstDesat = 0; firstHsPh = 0; firstLsPh = 0;
    cntDesat = 0; cntHsPh = 0; cntLsPh = 0;
  endtask

  // advance n edges, sampling at each following falling edge; edge 1 is the first after the call
  task automatic runEdges(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      idx++;
      if (hsEnable && firstHsEn == 0) firstHsEn = idx;
      if (lsEnable && firstLsEn == 0) firstLsEn = idx;
      if (desatFault) begin cntDesat++; if (firstDesat == 0) firstDesat = idx; end
      if (hsPhaseFault) begin cntHsPh++; if (firstHsPh == 0) firstHsPh = idx; end
      if (lsPhaseFault) begin cntLsPh++; if (firstLsPh == 0) firstLsPh = idx; end
    end
  endtask

  task automatic goIdle();
    hsCmd = 0; lsCmd = 0; desatRaw = 0; tripIn = 0;
    faultClear = 1;
    runEdges(1);
    faultClear = 0;
    runEdges(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    clearObs();
    repeat (3) @(negedge clk);
    // reset state (R1, R8)
    checkEq("R1", "reset hsEnable", int'(hsEnable), 0);
    checkEq("R1", "reset lsEnable", int'(lsEnable), 0);
    checkEq("R8", "reset tripOut", int'(tripOut), 0);
    checkEq("R5", "reset phase faults", int'(hsPhaseFault) + int'(lsPhaseFault), 0);
    rstN = 1'b1;
    runEdges(3);

    // sweep: side x node level x shutdown mode (R1 R2 R4 R5 R8 R9)
    for (int sideHi = 0; sideHi < 2; sideHi++) begin
      for (int ph = 0; ph < 2; ph++) begin
        for (int sd = 0; sd < 2; sd++) begin
          int bad;
          goIdle();
          phaseRaw = ph[0];
          sdDisable = sd[0];
          runEdges(3);
          hsCmd = (sideHi == 1);
          lsCmd = (sideHi == 0);
          clearObs();
          runEdges(D + B + 6);
          bad = (sideHi == 1) ? (ph == 0) : (ph == 1);
          checkEq("R2", "enable edge", (sideHi == 1) ? firstHsEn : firstLsEn, D + 1);
          checkEq("R1", "opposite gate seen", (sideHi == 1) ? firstLsEn : firstHsEn, 0);
          checkEq("R5", "own phase fault count", (sideHi == 1) ? cntHsPh : cntLsPh, bad);
          checkEq("R5", "other phase fault count", (sideHi == 1) ? cntLsPh : cntHsPh, 0);
          if (bad != 0)
            checkEq("R4", "phase fault edge", (sideHi == 1) ? firstHsPh : firstLsPh, D + B + 1);
          if (bad != 0 && sd == 0) begin
            checkEq("R8", "tripOut after fault", int'(tripOut), 1);
            checkEq("R8", "gate after trip", int'(hsEnable) + int'(lsEnable), 0);
          end else begin
            checkEq("R9", "tripOut stays low", int'(tripOut), 0);
            checkEq("R9", "gate still on", (sideHi == 1) ? int'(hsEnable) : int'(lsEnable), 1);
          end
        end
      end
    end

    // both requests together (R1)
    goIdle();
    hsCmd = 1; lsCmd = 1;
    clearObs();
    runEdges(D + B + 4);
    checkEq("R1", "both requested hi gate", firstHsEn, 0);
    checkEq("R1", "both requested lo gate", firstLsEn, 0);

    // desaturation pulse width sweep with shutdown disabled (R7 R9)
    goIdle();
    sdDisable = 1; phaseRaw = 1;
    runEdges(3);
    hsCmd = 1;
    runEdges(D + B + 4);
    for (int w = 1; w <= F + 2; w++) begin
      desatRaw = 1;
      clearObs();
      runEdges(w);
      desatRaw = 0;
      runEdges(S + F + 3);
      checkEq("R7", $sformatf("desat pulses width %0d", w), cntDesat, (w >= F) ? 1 : 0);
      if (w >= F) checkEq("R7", "desat fault edge", firstDesat, S + F);
      checkEq("R9", "gate on after desat", int'(hsEnable), 1);
    end

    // desaturation held across dead and blanking: counted only from run (R6)
    goIdle();
    sdDisable = 1; phaseRaw = 1; desatRaw = 1;
    runEdges(3);
    hsCmd = 1;
    clearObs();
    runEdges(D + B + F + 4);
    checkEq("R6", "desat edge after blanking", firstDesat, D + B + F + 1);
    checkEq("R7", "single pulse while held", cntDesat, 1);
    hsCmd = 0; lsCmd = 1; phaseRaw = 0;
    clearObs();
    runEdges(D + B + F + 6);
    checkEq("R6", "no desat with low side on", cntDesat, 0);
    checkEq("R2", "low side after swap", firstLsEn, D + 1);

    // desaturation trip, hold, clear (R8 R10)
    goIdle();
    sdDisable = 0; phaseRaw = 1;
    runEdges(3);
    hsCmd = 1;
    runEdges(D + B + 3);
    desatRaw = 1;
    clearObs();
    runEdges(S + F + 2);
    checkEq("R8", "desat trip edge", firstDesat, S + F);
    checkEq("R8", "tripOut on desat", int'(tripOut), 1);
    checkEq("R8", "gate off on desat", int'(hsEnable), 0);
    desatRaw = 0;
    clearObs();
    runEdges(10);
    checkEq("R10", "trip held", int'(tripOut), 1);
    checkEq("R10", "gate held off", firstHsEn, 0);
    faultClear = 1;
    clearObs();
    runEdges(1);
    faultClear = 0;
    runEdges(D + 4);
    checkEq("R10", "tripOut cleared", int'(tripOut), 0);
    checkEq("R10", "enable after clear", firstHsEn, D + 2);

    // request change in the last blanking cycle (R3)
    goIdle();
    sdDisable = 1; phaseRaw = 0;
    runEdges(3);
    hsCmd = 1;
    clearObs();
    runEdges(D + 2);
    begin
      int earlyHs;
      earlyHs = cntHsPh;
      hsCmd = 0; lsCmd = 1;
      clearObs();
      runEdges(D + B + 5);
      checkEq("R3", "abandoned high-side check", earlyHs + cntHsPh, 0);
      checkEq("R3", "low-side check clean", cntLsPh, 0);
      checkEq("R3", "low side restart edge", firstLsEn, D + 1);
    end

    // trip from other phases (R11)
    tripIn = 1;
    clearObs();
    runEdges(1);
    checkEq("R11", "gate off on tripIn", int'(lsEnable), 0);
    runEdges(5);
    checkEq("R11", "gate stays off", int'(lsEnable), 0);
    checkEq("R11", "tripOut unaffected", int'(tripOut), 0);
    tripIn = 0;
    clearObs();
    runEdges(D + 3);
    checkEq("R11", "enable after tripIn", firstLsEn, D + 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule